// File: doc/BRIEF.md
# Next-PC Selection Unit

This combinational block picks the address of the next instruction for a 32-bit, fixed-width-instruction processor. It looks at the current program counter, the fetched instruction word, the value read from the first source register and a flag that says whether the two source registers compare equal. From these it produces the next fetch address. It also produces the value and the destination index for a return-address write.

An internal decoder sorts every instruction into one of six flow kinds: FLOW_SEQ, FLOW_BEQ, FLOW_BNE, FLOW_JMP, FLOW_JAL and FLOW_JREG. There is no state register, so no transitions exist. Each flow kind maps directly to a target source: the sequential address, the PC-relative branch target, the region jump target or the register value. A target generator computes all three candidate addresses in parallel, and a selector chooses one of them based on the flow kind. Exceptions and delay slots are outside this block.

Top module: `npc_select`

## Requirements
- R1: Any opcode other than 0, 2, 3, 4 or 5 gives FLOW_SEQ. The same applies to opcode 0 when the funct field (bits 5:0) is not 8. In FLOW_SEQ, next_pc equals pc_now + 4.
- R2: Opcode 4 (branch-if-equal) takes next_pc = pc_now + 4 + 4 × sign-extended bits 15:0 when rs_eq_rt is 1. When rs_eq_rt is 0, next_pc is pc_now + 4.
- R3: Opcode 5 (branch-if-not-equal) takes the same branch target when rs_eq_rt is 0. When rs_eq_rt is 1, next_pc is pc_now + 4.
- R4: A negative 16-bit offset moves the target backward from pc_now + 4. For example, 0xFFFE from pc 0x1000 gives 0x0FFC.
- R5: Opcode 2 (jump) gives next_pc = {(pc_now+4)[31:28], bits 25:0, 2'b00}. The upper nibble is taken from pc_now + 4, not from pc_now.
- R6: Opcode 3 (jump-and-link) gives the same target as R5. It also sets link_we to 1 and link_reg to 31.
- R7: Opcode 0 with funct 8 (register jump) gives next_pc = rs_value.
- R8: link_value always equals pc_now + 4. For every kind other than FLOW_JAL, link_we is 0.
- R9: Address arithmetic wraps modulo 2^32. Sequential flow from 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_now | input | 32 | Address of the current instruction |
| instr_word | input | 32 | Current instruction word |
| rs_value | input | 32 | Value of the first source register |
| rs_eq_rt | input | 1 | Source registers compare equal |
| next_pc | output | 32 | Selected next fetch address |
| link_value | output | 32 | Return address, pc_now + 4 |
| link_we | output | 1 | Write link_value to the return register |
| link_reg | output | 5 | Index of the return register |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 16-bit branch offset and a 26-bit jump index. These defaults make several boundary cases reachable:
- a jump whose upper nibble changes between pc and pc+4 (0x1FFFFFFC),
- the carry out of the top address bit,
- full-range negative offsets.

Directed values follow the encoded-jump example: field 0x0100008 must land at 0x00400020. The bench also uses a forward offset of 25, which must land 100 bytes past pc+4.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JREG
    } flow_e;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_JMP     = 6'd2;
    localparam logic [5:0] OPC_JAL     = 6'd3;
    localparam logic [5:0] OPC_BEQ     = 6'd4;
    localparam logic [5:0] OPC_BNE     = 6'd5;
    localparam logic [5:0] FN_JREG     = 6'd8;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output flow_e      kind
);
    always_comb begin
        kind = FLOW_SEQ;
        unique case (opcode)
            OPC_SPECIAL: kind = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            OPC_JMP:     kind = FLOW_JMP;
            OPC_JAL:     kind = FLOW_JAL;
            OPC_BEQ:     kind = FLOW_BEQ;
            OPC_BNE:     kind = FLOW_BNE;
            default:     kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IMM_W-1:0]  br_off,
    input  logic [JIDX_W-1:0] jidx,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] br_addr,
    output logic [ADDR_W-1:0] jmp_addr
);
    localparam int EXT_W = ADDR_W - IMM_W - 2;
    localparam int HI_W  = ADDR_W - JIDX_W - 2;

    logic [ADDR_W-1:0] br_disp;

    always_comb begin
        seq_addr = pc + ADDR_W'(4);
        br_disp  = {{EXT_W{br_off[IMM_W-1]}}, br_off, 2'b00};
        br_addr  = seq_addr + br_disp;
        jmp_addr = {seq_addr[ADDR_W-1 -: HI_W], jidx, 2'b00};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IMM_W     = 16,
    parameter int JIDX_W    = 26,
    parameter int RIDX_W    = 5,
    parameter int LINK_IDX  = 31
) (
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [31:0]       instr_word,
    input  logic [ADDR_W-1:0] rs_value,
    input  logic              rs_eq_rt,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] link_value,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_reg
);
    flow_e             kind;
    logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr;

    npc_decode u_dec (
        .opcode (instr_word[31:26]),
        .funct  (instr_word[5:0]),
        .kind   (kind)
    );

    npc_targets #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
        .pc       (pc_now),
        .br_off   (instr_word[IMM_W-1:0]),
        .jidx     (instr_word[JIDX_W-1:0]),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    always_comb begin
        next_pc = seq_addr;
        link_we = 1'b0;
        unique case (kind)
            FLOW_SEQ:  next_pc = seq_addr;
            FLOW_BEQ:  next_pc = rs_eq_rt ? br_addr : seq_addr;
            FLOW_BNE:  next_pc = rs_eq_rt ? seq_addr : br_addr;
            FLOW_JMP:  next_pc = jmp_addr;
            FLOW_JAL: begin
                next_pc = jmp_addr;
                link_we = 1'b1;
            end
            FLOW_JREG: next_pc = rs_value;
            default:   next_pc = seq_addr;
        endcase
        link_value = seq_addr;
        link_reg   = RIDX_W'(LINK_IDX);
    end
endmodule

// File: rtl/npc_select_chk.sv
module npc_select_chk #(
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5
) (
    input logic [5:0]        op,
    input logic [5:0]        fn,
    input logic              eq,
    input logic [ADDR_W-1:0] rs_v,
    input logic [ADDR_W-1:0] npc,
    input logic [ADDR_W-1:0] lval,
    input logic              lwe,
    input logic [RIDX_W-1:0] lreg
);
    always_comb begin
        if (op == 6'd0 && fn == 6'd8)
            a_r7_jreg_target: assert (npc == rs_v);
        if (op == 6'd2 || op == 6'd3)
            a_r5_jump_upper: assert (npc[ADDR_W-1 -: 4] == lval[ADDR_W-1 -: 4] && npc[1:0] == 2'b00);
        if (op == 6'd4 && !eq)
            a_r2_beq_fallthru: assert (npc == lval);
        if (op == 6'd5 && eq)
            a_r3_bne_fallthru: assert (npc == lval);
        if (lwe)
            a_r6_link_index: assert (lreg == RIDX_W'(31) && op == 6'd3);
    end
endmodule

bind npc_select npc_select_chk #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_chk (
    .op   (instr_word[31:26]),
    .fn   (instr_word[5:0]),
    .eq   (rs_eq_rt),
    .rs_v (rs_value),
    .npc  (next_pc),
    .lval (link_value),
    .lwe  (link_we),
    .lreg (link_reg)
);

// File: tb/sim_npc_select.sv
module sim_npc_select;
    logic        clk = 1'b0;
    logic [31:0] pc_now, instr_word, rs_value, next_pc, link_value;
    logic        rs_eq_rt, link_we;
    logic [4:0]  link_reg;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    npc_select u0 (
        .pc_now(pc_now), .instr_word(instr_word), .rs_value(rs_value),
        .rs_eq_rt(rs_eq_rt), .next_pc(next_pc), .link_value(link_value),
        .link_we(link_we), .link_reg(link_reg)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd3, 5'd4, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] pc, input logic [31:0] iw,
                         input logic [31:0] rv, input logic eq);
        @(posedge clk);
        pc_now = pc; instr_word = iw; rs_value = rv; rs_eq_rt = eq;
        @(negedge clk);
    endtask

    task automatic t_sequential();
        apply(32'h0000_0100, 32'h2000_0005, 32'hDEAD_BEEF, 1'b1);
        check("R1 addi seq", next_pc, 32'h0000_0104);
        check("R8 no link", {31'd0, link_we}, 32'd0);
        apply(32'h0000_0200, 32'h0085_1820, 32'h0000_0040, 1'b0);
        check("R1 op0 funct20 seq", next_pc, 32'h0000_0204);
        check("R8 link value", link_value, 32'h0000_0204);
    endtask

    task automatic t_beq();
        apply(32'h0000_0100, enc_i(6'd4, 16'd25), 32'h0, 1'b1);
        check("R2 beq taken +25", next_pc, 32'h0000_0168);
        apply(32'h0000_0100, enc_i(6'd4, 16'd25), 32'h0, 1'b0);
        check("R2 beq not taken", next_pc, 32'h0000_0104);
    endtask

    task automatic t_bne();
        apply(32'h0000_0400, enc_i(6'd5, 16'd3), 32'h0, 1'b0);
        check("R3 bne taken", next_pc, 32'h0000_0410);
        apply(32'h0000_0400, enc_i(6'd5, 16'd3), 32'h0, 1'b1);
        check("R3 bne not taken", next_pc, 32'h0000_0404);
    endtask

    task automatic t_backward();
        apply(32'h0000_1000, enc_i(6'd4, 16'hFFFE), 32'h0, 1'b1);
        check("R4 beq back -2", next_pc, 32'h0000_0FFC);
        apply(32'h0000_1000, enc_i(6'd5, 16'h8000), 32'h0, 1'b0);
        check("R4 bne back min", next_pc, 32'hFFFE_1004);
    endtask

    task automatic t_jump();
        apply(32'h0040_0000, enc_j(6'd2, 26'h010_0008), 32'h0, 1'b0);
        check("R5 jump example", next_pc, 32'h0040_0020);
        apply(32'h1FFF_FFFC, enc_j(6'd2, 26'h000_0010), 32'h0, 1'b0);
        check("R5 nibble from pc+4", next_pc, 32'h2000_0040);
        check("R8 jump no link", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_jal();
        apply(32'hA000_0010, enc_j(6'd3, 26'h3FF_FFFF), 32'h0, 1'b1);
        check("R6 jal target", next_pc, 32'hAFFF_FFFC);
        check("R6 jal link_we", {31'd0, link_we}, 32'd1);
        check("R6 jal link_reg", {27'd0, link_reg}, 32'd31);
        check("R6 jal link value", link_value, 32'hA000_0014);
    endtask

    task automatic t_jreg();
        apply(32'h0000_3000, 32'h03E0_0008, 32'h1234_5678, 1'b0);
        check("R7 jreg target", next_pc, 32'h1234_5678);
        check("R8 jreg no link", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_wrap();
        apply(32'hFFFF_FFFC, 32'h2000_0000, 32'h0, 1'b0);
        check("R9 seq wrap", next_pc, 32'h0000_0000);
        apply(32'hFFFF_FFF8, enc_i(6'd4, 16'd2), 32'h0, 1'b1);
        check("R9 branch wrap", next_pc, 32'h0000_0004);
    endtask

    initial begin
        pc_now = 32'h0; instr_word = 32'h0; rs_value = 32'h0; rs_eq_rt = 1'b0;
        @(negedge clk);
        check("R1 idle state", next_pc, 32'h0000_0004);
        t_sequential();
        t_beq();
        t_bne();
        t_backward();
        t_jump();
        t_jal();
        t_jreg();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 10000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule